// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every internal data transfer of a read or write burst in a double-data-rate memory device. A one-cycle start pulse captures a starting column, a burst length code and an ordering select. From the next clock on, the block presents one column address per cycle until the burst is complete, and it flags the final beat. The same captured length and ordering serve both read and write bursts.

Each burst stays inside an aligned group of columns whose size equals the burst length. The low bits of the start column pick the first position in that group, and the address wraps at the group's edge instead of carrying into the upper bits. There are two orderings. Linear ordering adds the beat number modulo the length. Interleaved ordering XORs the beat number into the low bits.

There are two states. `ST_IDLE` moves to `ST_BURST` on a start pulse. `ST_BURST` stays in `ST_BURST` while beats remain, and also when a new start pulse arrives, which restarts the burst. It returns to `ST_IDLE` after the final beat if no start pulse arrives.

Top module: `burst_col_seq`

## Requirements
- R1: When `start` is sampled high at clock edge n, `col_valid` is high after edges n through n+L-1, and the address for beat k (k = 0 .. L-1) appears after edge n+k.
- R2: The address for beat 0 equals `start_col` exactly.
- R3: `len_sel` sets the burst length L: code 0 gives 2, code 1 gives 4, and codes 2 and 3 both give 8.
- R4: When `ilv_sel` is 0 (linear), the low log2(L) bits of beat k are (start low bits + k) modulo L.
- R5: When `ilv_sel` is 1 (interleaved), the low log2(L) bits of beat k are the start low bits XOR k.
- R6: Every column bit at or above position log2(L) keeps its value from `start_col` on every beat of the burst.
- R7: `last_beat` is high only on beat L-1. If no start pulse comes in that cycle, `col_valid` is low after the next edge.
- R8: A start pulse during a burst abandons the rest of that burst, and the new burst begins at beat 0 after the next edge.
- R9: Length and ordering are captured only with the start pulse. Changes on `len_sel` or `ilv_sel` during a burst do not alter that burst.
- R10: During and right after reset, `col_valid`, `last_beat` and `col_out` are all 0.
- R11: A start pulse sampled on the final beat begins the next burst with no idle cycle between the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse that captures the burst parameters |
| start_col | input | 9 | Starting column address |
| len_sel | input | 2 | Burst length code (0:2, 1:4, 2/3:8) |
| ilv_sel | input | 1 | Ordering select: 0 linear, 1 interleaved |
| col_out | output | 9 | Column address of the current beat (0 when idle) |
| col_valid | output | 1 | High while a beat is being presented |
| last_beat | output | 1 | High on the final beat of a burst |

## Verification
Beat k of a burst whose start pulse is sampled at edge n is due after edge n+k. The drop of `col_valid` is due after edge n+L. The bench drives every input on the falling edge and reads the outputs on the following falling edges, one beat per half period after each rising edge. It therefore compares beat 0 at the first falling edge after the start edge and beat k k cycles later. Restart and back-to-back cases drive the new pulse in the same half cycle in which the bench reads the beat being replaced or the final beat, so the new beat 0 is due one cycle later.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // widest burst is 8 beats -> 3 offset bits
    localparam int OFS_W = 3;

    typedef enum logic [1:0] {
        BL_2  = 2'd0,
        BL_4  = 2'd1,
        BL_8  = 2'd2,
        BL_8X = 2'd3
    } blen_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } bstate_e;

    typedef struct packed {
        blen_e len;
        logic  ilv;
    } bcfg_t;

    // mask of the in-block offset bits; also the index of the final beat
    function automatic logic [OFS_W-1:0] len_mask(input blen_e l);
        logic [OFS_W-1:0] m;
        unique case (l)
            BL_2:    m = 3'd1;
            BL_4:    m = 3'd3;
            default: m = 3'd7;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/burst_beat_ctl.sv
module burst_beat_ctl
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [COL_W-1:0]     start_col,
    input  logic [1:0]           len_sel,
    input  logic                 ilv_sel,
    output logic [COL_W-1:0]     base_q,
    output bcfg_t                cfg_q,
    output logic [OFS_W-1:0]     beat_q,
    output logic                 busy,
    output logic                 is_last
);

    bstate_e state_q, state_d;

    // output decode
    always_comb begin
        busy    = (state_q == ST_BURST);
        is_last = busy && (beat_q == len_mask(cfg_q.len));
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = start ? ST_BURST : ST_IDLE;
            ST_BURST: begin
                if (start)        state_d = ST_BURST;
                else if (is_last) state_d = ST_IDLE;
                else              state_d = ST_BURST;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and captured burst parameters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            base_q  <= '0;
            cfg_q   <= '{len: BL_2, ilv: 1'b0};
        end else begin
            state_q <= state_d;
            if (start) begin
                beat_q  <= '0;
                base_q  <= start_col;
                cfg_q   <= '{len: blen_e'(len_sel), ilv: ilv_sel};
            end else if (busy && !is_last) begin
                beat_q  <= beat_q + 3'd1;
            end
        end
    end

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !is_last && !start |=> beat_q == $past(beat_q) + 3'd1); // R1
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !start |=> cfg_q == $past(cfg_q)); // R9
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy && beat_q == '0); // R8

endmodule

// File: rtl/burst_ofs_gen.sv
module burst_ofs_gen
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  bcfg_t            cfg,
    input  logic [OFS_W-1:0] beat,
    output logic [COL_W-1:0] col
);

    logic [OFS_W-1:0] mask;
    logic [OFS_W-1:0] lo_lin;
    logic [OFS_W-1:0] lo_xor;
    logic [OFS_W-1:0] lo_sel;

    always_comb begin
        mask   = len_mask(cfg.len);
        lo_lin = base[OFS_W-1:0] + beat;
        lo_xor = base[OFS_W-1:0] ^ beat;
        lo_sel = cfg.ilv ? lo_xor : lo_lin;
    end

    // per offset bit: inside the block take the new value, outside keep base
    for (genvar i = 0; i < OFS_W; i++) begin : g_ofs
        assign col[i] = mask[i] ? lo_sel[i] : base[i];
    end

    assign col[COL_W-1:OFS_W] = base[COL_W-1:OFS_W];

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [1:0]       len_sel,
    input  logic             ilv_sel,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic             last_beat
);

    logic [COL_W-1:0] base_q;
    bcfg_t            cfg_q;
    logic [OFS_W-1:0] beat_q;
    logic             busy;
    logic             is_last;
    logic [COL_W-1:0] gen_col;

    burst_beat_ctl #(.COL_W(COL_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_col (start_col),
        .len_sel   (len_sel),
        .ilv_sel   (ilv_sel),
        .base_q    (base_q),
        .cfg_q     (cfg_q),
        .beat_q    (beat_q),
        .busy      (busy),
        .is_last   (is_last)
    );

    burst_ofs_gen #(.COL_W(COL_W)) u_ofs (
        .base (base_q),
        .cfg  (cfg_q),
        .beat (beat_q),
        .col  (gen_col)
    );

    always_comb begin
        col_valid = busy;
        last_beat = is_last;
        col_out   = busy ? gen_col : '0;
    end

    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> col_valid && col_out == $past(start_col)); // R2
    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && !start |=> !col_valid || col_out[COL_W-1:OFS_W] == $past(col_out[COL_W-1:OFS_W])); // R6
    AST_LAST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat && !start |=> !col_valid); // R7
    AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> col_valid); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid |-> col_out == '0 && !last_beat); // R10

endmodule

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;

    localparam int COL_W = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [1:0]       len_sel = 2'd0;
    logic             ilv_sel = 1'b0;
    logic [COL_W-1:0] col_out;
    logic             col_valid;
    logic             last_beat;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_col (start_col),
        .len_sel   (len_sel),
        .ilv_sel   (ilv_sel),
        .col_out   (col_out),
        .col_valid (col_valid),
        .last_beat (last_beat)
    );

    function automatic int len_of(input logic [1:0] code);
        return (code == 2'd0) ? 2 : (code == 2'd1) ? 4 : 8;
    endfunction

    function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s,
                                                 input int L, input bit il, input int k);
        int lo;
        int m;
        m  = L - 1;
        lo = il ? ((s & m) ^ k) : (((s & m) + k) % L);
        return COL_W'((int'(s) & ~m) | lo);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // assumes we are at a falling edge
    task automatic launch(input logic [COL_W-1:0] s, input logic [1:0] l, input bit il);
        start     = 1'b1;
        start_col = s;
        len_sel   = l;
        ilv_sel   = il;
    endtask

    // follows beats 0..n_beats-1; optional restart on final sampled beat
    task automatic follow(input logic [COL_W-1:0] s, input logic [1:0] l, input bit il,
                          input int n_beats, input string tag);
        int L;
        L = len_of(l);
        for (int k = 0; k < n_beats; k++) begin
            @(negedge clk);
            if (k == 0) start = 1'b0;
            check(col_valid == 1'b1, {tag, " R1 valid"}, int'(col_valid), 1);
            check(col_out == exp_col(s, L, il, k), {tag, il ? " R5 col" : " R4 col"},
                  int'(col_out), int'(exp_col(s, L, il, k)));
            check(last_beat == (k == L - 1), {tag, " R7 last"}, int'(last_beat), int'(k == L - 1));
        end
    endtask

    task automatic expect_idle(input string tag);
        @(negedge clk);
        check(col_valid == 1'b0, {tag, " R7 valid drop"}, int'(col_valid), 0);
        check(col_out == '0, {tag, " R10 idle col"}, int'(col_out), 0);
    endtask

    task automatic t_reset();
        check(col_valid == 1'b0, "R10 valid", int'(col_valid), 0);
        check(last_beat == 1'b0, "R10 last", int'(last_beat), 0);
        check(col_out == '0, "R10 col", int'(col_out), 0);
    endtask

    task automatic t_burst(input logic [COL_W-1:0] s, input logic [1:0] l, input bit il,
                           input string tag);
        launch(s, l, il);
        follow(s, l, il, len_of(l), tag);
        expect_idle(tag);
    endtask

    task automatic t_abort();
        launch(9'h040, 2'd2, 1'b0);
        follow(9'h040, 2'd2, 1'b0, 3, "R8 first");
        launch(9'h0F3, 2'd1, 1'b1);
        follow(9'h0F3, 2'd1, 1'b1, 4, "R8 restarted");
        expect_idle("R8");
    endtask

    task automatic t_ignore();
        launch(9'h0C5, 2'd0, 1'b0);
        @(negedge clk);
        start   = 1'b0;
        len_sel = 2'd2;
        ilv_sel = 1'b1;
        check(col_out == 9'h0C5, "R9 beat0", int'(col_out), 'h0C5);
        @(negedge clk);
        check(col_out == 9'h0C4, "R9 beat1", int'(col_out), 'h0C4);
        check(last_beat == 1'b1, "R9 last", int'(last_beat), 1);
        expect_idle("R9");
    endtask

    task automatic t_back_to_back();
        launch(9'h1A1, 2'd0, 1'b0);
        follow(9'h1A1, 2'd0, 1'b0, 2, "R11 a");
        launch(9'h036, 2'd1, 1'b0);
        follow(9'h036, 2'd1, 1'b0, 4, "R11 b");
        expect_idle("R11");
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_burst(9'h1FF, 2'd0, 1'b0, "R2 R6 lin2");
        t_burst(9'h0A6, 2'd1, 1'b0, "R3 lin4");
        t_burst(9'h13D, 2'd2, 1'b0, "R6 lin8");
        t_burst(9'h0A7, 2'd1, 1'b1, "R5 ilv4");
        t_burst(9'h16B, 2'd2, 1'b1, "R5 ilv8");
        t_burst(9'h005, 2'd0, 1'b1, "R5 ilv2");
        t_burst(9'h102, 2'd3, 1'b0, "R3 code3");
        t_abort();
        t_ignore();
        t_back_to_back();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule